// File: doc/BRIEF.md
# ADC Conversion Trigger Sequencer

This block sequences one conversion of a sampling ADC. It runs on the ADC clock. A 3-bit source-select input picks the event that starts a conversion. That event can be a strobe from one of three timers, a rising edge or a falling edge on an external convert pin, a software start pulse, or free-running repetition. When the selected event is accepted, the block puts the track/hold stage into track. It then counts a track interval whose length depends on two settings: whether the converter powers down between conversions, and whether the amplifier gain is unity.

At the end of the track interval the block asserts hold and runs a successive-approximation phase of fixed length. During that phase it collects one comparator decision per cycle into a result word. In the last cycle of the phase it publishes the result and raises a one-cycle done strobe. A busy flag covers the whole sequence and also serves as the software status bit.

Top module: `adc_trig_seq`

## Requirements
- R1: While rst_n is low, and in the first cycle after reset, track, hold, busy and done are 0 and result is 0. Asserting rst_n low in the middle of a conversion clears all of these at once.
- R2: src_sel 3'b000, 3'b001 and 3'b010 pick tmr_stb[0], tmr_stb[1] and tmr_stb[2]. src_sel 3'b111 picks sw_start. A one-cycle pulse on the selected input while idle sets track and busy from the following clock edge.
- R3: src_sel 3'b100 starts on a rising edge of conv_pin and 3'b101 on a falling edge. The pin passes through a two-flop synchronizer, so track rises on the third clock edge after the pin changes and not earlier.
- R4: Pulses on sources that are not selected start nothing, and src_sel 3'b011 never starts a conversion.
- R5: Track lasts 13 cycles (auto_shdn=1, gain_unity=1), 93 cycles (auto_shdn=1, gain_unity=0), 3 cycles (auto_shdn=0, gain_unity=1) or 43 cycles (auto_shdn=0, gain_unity=0). Hold rises in the cycle in which track falls.
- R6: Hold stays high for exactly 13 cycles. In the cycle after the last hold cycle, done is 1 for exactly one cycle.
- R7: The comparator input sampled in hold cycle k (k = 0..11) becomes result bit 11-k, so bits are resolved MSB first. result updates only in the cycle done is high and keeps its value until the next done.
- R8: Trigger events that arrive while busy is 1 are ignored. They neither shorten nor extend the running conversion, and they do not start a new conversion after it.
- R9: src_sel 3'b110 starts conversions on its own while idle. These conversions always use the 3- or 43-cycle track timing, whatever auto_shdn is set to. A new track phase begins in the same cycle done is high, so conversions repeat every 16 (gain_unity=1) or 56 (gain_unity=0) cycles until src_sel is changed.
- R10: busy is 1 from the first track cycle through the last hold cycle. It is 0 in the done cycle unless free-running mode continues.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | ADC clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously upstream |
| src_sel | input | 3 | Trigger source select |
| tmr_stb | input | 3 | Single-cycle timer strobes, one per timer |
| conv_pin | input | 1 | External convert pin, asynchronous |
| sw_start | input | 1 | Software start pulse (write of 1 to the start bit) |
| auto_shdn | input | 1 | 1: converter powers down between conversions |
| gain_unity | input | 1 | 1: amplifier gain equals 1 |
| cmp_in | input | 1 | Comparator decision for the bit under trial |
| track | output | 1 | Track/hold in track mode |
| hold | output | 1 | Track/hold in hold mode, SAR running |
| busy | output | 1 | Conversion in progress (start-bit readback) |
| done | output | 1 | One-cycle strobe when result is updated |
| result | output | 12 | Last completed conversion word |

## Verification
The bench uses the default parameters: a 12-bit result and track lengths of 3, 13, 43 and 93 cycles. Every timing corner is therefore measured in real cycle counts. These include the shortest and longest single conversions (16 and 106 cycles) and both free-running periods (16 and 56 cycles). A full test of every source and setting still fits in a few thousand cycles. The all-ones, all-zeros and single-bit patterns confirm that the bit order and the update of the result word are correct.

// File: rtl/adc_trig_pkg.sv
package adc_trig_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_TRACK = 2'd1,
    ST_CONV  = 2'd2
  } seq_state_t;

  localparam logic [2:0] SRC_TMR0 = 3'b000;
  localparam logic [2:0] SRC_TMR1 = 3'b001;
  localparam logic [2:0] SRC_TMR2 = 3'b010;
  localparam logic [2:0] SRC_RISE = 3'b100;
  localparam logic [2:0] SRC_FALL = 3'b101;
  localparam logic [2:0] SRC_FREE = 3'b110;
  localparam logic [2:0] SRC_SOFT = 3'b111;

  function automatic int imax(input int a, input int b);
    return (a > b) ? a : b;
  endfunction

endpackage

// File: rtl/adc_trig_src.sv
module adc_trig_src
  import adc_trig_pkg::*;
#(
  parameter int NTMR        = 3,
  parameter int SYNC_STAGES = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic [2:0]      src_sel,
  input  logic [NTMR-1:0] tmr_stb,
  input  logic            conv_pin,
  input  logic            sw_start,
  output logic            trig,
  output logic            free_run
);

  localparam int PQ_W = SYNC_STAGES + 1;

  logic [PQ_W-1:0] pin_q;
  logic [PQ_W-1:0] pin_d;
  logic            pin_rise;
  logic            pin_fall;
  logic [NTMR-1:0] tmr_hit;

  // Synchronizer plus one delay stage for edge detection
  always_comb pin_d = {pin_q[PQ_W-2:0], conv_pin};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) pin_q <= '0;
    else        pin_q <= pin_d;
  end

  assign pin_rise = pin_q[SYNC_STAGES-1] & ~pin_q[SYNC_STAGES];
  assign pin_fall = ~pin_q[SYNC_STAGES-1] & pin_q[SYNC_STAGES];

  genvar gi;
  generate
    for (gi = 0; gi < NTMR; gi++) begin : g_tmr
      assign tmr_hit[gi] = (src_sel == 3'(gi)) & tmr_stb[gi];
    end
  endgenerate

  always_comb begin
    free_run = 1'b0;
    case (src_sel)
      SRC_RISE: trig = pin_rise;
      SRC_FALL: trig = pin_fall;
      SRC_FREE: begin
        trig     = 1'b1;
        free_run = 1'b1;
      end
      SRC_SOFT: trig = sw_start;
      default:  trig = |tmr_hit;
    endcase
  end

  // R4: the unused code never yields a start
  p_unused_code_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (src_sel == 3'b011) |-> !trig);

endmodule

// File: rtl/adc_trig_fsm.sv
module adc_trig_fsm
  import adc_trig_pkg::*;
#(
  parameter int TRK_SD_UNITY = 13,
  parameter int TRK_SD_GAIN  = 93,
  parameter int TRK_ON_UNITY = 3,
  parameter int TRK_ON_GAIN  = 43,
  parameter int CONV_CYC     = 13,
  parameter int CW           = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig,
  input  logic          free_run,
  input  logic          auto_shdn,
  input  logic          gain_unity,
  output logic          track,
  output logic          hold,
  output logic          busy,
  output logic [CW-1:0] cnt
);

  seq_state_t    st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  int            len_sel;
  int            len_free;

  always_comb begin
    len_free = gain_unity ? TRK_ON_UNITY : TRK_ON_GAIN;
    if (free_run)       len_sel = len_free;
    else if (auto_shdn) len_sel = gain_unity ? TRK_SD_UNITY : TRK_SD_GAIN;
    else                len_sel = len_free;
  end

  always_comb begin
    st_d  = st_q;
    cnt_d = cnt_q;
    case (st_q)
      ST_IDLE: begin
        if (trig) begin
          st_d  = ST_TRACK;
          cnt_d = CW'(len_sel - 1);
        end
      end
      ST_TRACK: begin
        if (cnt_q == '0) begin
          st_d  = ST_CONV;
          cnt_d = CW'(CONV_CYC - 1);
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      ST_CONV: begin
        if (cnt_q == '0) begin
          if (free_run) begin
            st_d  = ST_TRACK;
            cnt_d = CW'(len_free - 1);
          end else begin
            st_d = ST_IDLE;
          end
        end else begin
          cnt_d = cnt_q - 1'b1;
        end
      end
      default: st_d = ST_IDLE;
    endcase
  end

  assign cnt_en = (st_q != ST_IDLE) | trig;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= ST_IDLE;
      cnt_q <= '0;
    end else begin
      st_q <= st_d;
      if (cnt_en) cnt_q <= cnt_d;
    end
  end

  assign track = (st_q == ST_TRACK);
  assign hold  = (st_q == ST_CONV);
  assign busy  = (st_q != ST_IDLE);
  assign cnt   = cnt_q;

  // R6: track and hold are never both active
  p_track_hold_excl_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !(track && hold));
  // R2: a new sequence always opens with track
  p_start_in_track_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> track);
  // R5: hold follows directly on track
  p_hold_after_track_r5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(hold) |-> $past(track));
  // R8: busy cannot drop before the last hold cycle
  p_busy_kept_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !(hold && cnt_q == '0)) |=> busy);
  // R9: free-running mode re-enters track right after the last hold cycle
  p_free_restart_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (hold && cnt_q == '0 && free_run) |=> track);

endmodule

// File: rtl/adc_trig_sar.sv
module adc_trig_sar #(
  parameter int RES_W = 12,
  parameter int CW    = 7
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             hold,
  input  logic [CW-1:0]    cnt,
  input  logic             cmp_in,
  output logic [RES_W-1:0] result,
  output logic             done
);

  logic [RES_W-1:0] sar_q, sar_d;
  logic [RES_W-1:0] res_q;
  logic             done_q;
  logic             res_en;

  // Counter value i+1 during hold resolves bit i (MSB first)
  always_comb begin
    sar_d = sar_q;
    for (int i = 0; i < RES_W; i++) begin
      if (hold && cnt == CW'(i + 1)) sar_d[i] = cmp_in;
    end
  end

  assign res_en = hold && (cnt == '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sar_q  <= '0;
      res_q  <= '0;
      done_q <= 1'b0;
    end else begin
      if (hold)   sar_q <= sar_d;
      if (res_en) res_q <= sar_q;
      done_q <= res_en;
    end
  end

  assign result = res_q;
  assign done   = done_q;

  // R6: done only follows a hold cycle
  p_done_after_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(hold));
  // R6: done is a single-cycle strobe
  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);
  // R7: result only moves together with done
  p_result_stable_r7: assert property (@(posedge clk) disable iff (!rst_n)
    !done |-> $stable(result));

endmodule

// File: rtl/adc_trig_seq.sv
module adc_trig_seq
  import adc_trig_pkg::*;
#(
  parameter int RES_W        = 12,
  parameter int TRK_SD_UNITY = 13,
  parameter int TRK_SD_GAIN  = 93,
  parameter int TRK_ON_UNITY = 3,
  parameter int TRK_ON_GAIN  = 43
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [2:0]       src_sel,
  input  logic [2:0]       tmr_stb,
  input  logic             conv_pin,
  input  logic             sw_start,
  input  logic             auto_shdn,
  input  logic             gain_unity,
  input  logic             cmp_in,
  output logic             track,
  output logic             hold,
  output logic             busy,
  output logic             done,
  output logic [RES_W-1:0] result
);

  localparam int NTMR     = 3;
  localparam int CONV_CYC = RES_W + 1;
  localparam int MAXLEN   = imax(imax(TRK_SD_UNITY, TRK_SD_GAIN),
                                 imax(imax(TRK_ON_UNITY, TRK_ON_GAIN), CONV_CYC));
  localparam int CW       = $clog2(MAXLEN);

  logic          trig;
  logic          free_run;
  logic [CW-1:0] cnt;

  adc_trig_src #(.NTMR(NTMR), .SYNC_STAGES(2)) u_src (
    .clk      (clk),
    .rst_n    (rst_n),
    .src_sel  (src_sel),
    .tmr_stb  (tmr_stb),
    .conv_pin (conv_pin),
    .sw_start (sw_start),
    .trig     (trig),
    .free_run (free_run)
  );

  adc_trig_fsm #(
    .TRK_SD_UNITY (TRK_SD_UNITY),
    .TRK_SD_GAIN  (TRK_SD_GAIN),
    .TRK_ON_UNITY (TRK_ON_UNITY),
    .TRK_ON_GAIN  (TRK_ON_GAIN),
    .CONV_CYC     (CONV_CYC),
    .CW           (CW)
  ) u_fsm (
    .clk        (clk),
    .rst_n      (rst_n),
    .trig       (trig),
    .free_run   (free_run),
    .auto_shdn  (auto_shdn),
    .gain_unity (gain_unity),
    .track      (track),
    .hold       (hold),
    .busy       (busy),
    .cnt        (cnt)
  );

  adc_trig_sar #(.RES_W(RES_W), .CW(CW)) u_sar (
    .clk    (clk),
    .rst_n  (rst_n),
    .hold   (hold),
    .cnt    (cnt),
    .cmp_in (cmp_in),
    .result (result),
    .done   (done)
  );

endmodule

// File: tb/adc_trig_seq_tb_top.sv
`timescale 1ns/1ps
module adc_trig_seq_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [2:0]  src_sel;
  logic [2:0]  tmr_stb;
  logic        conv_pin;
  logic        sw_start;
  logic        auto_shdn;
  logic        gain_unity;
  logic        cmp_in;
  logic        track, hold, busy, done;
  logic [11:0] result;

  int checks = 0;
  int errors = 0;

  always #5 clk = ~clk;

  adc_trig_seq dut_i (
    .clk(clk), .rst_n(rst_n), .src_sel(src_sel), .tmr_stb(tmr_stb),
    .conv_pin(conv_pin), .sw_start(sw_start), .auto_shdn(auto_shdn),
    .gain_unity(gain_unity), .cmp_in(cmp_in), .track(track), .hold(hold),
    .busy(busy), .done(done), .result(result)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // Called at the first negedge after the trigger edge; returns at the done cycle
  task automatic do_conv(input int exp_n, input logic [11:0] pat, input bit cont);
    int tc = 0;
    int hc = 0;
    int nb = 0;
    while (track && tc < 200) begin
      if (!busy) nb++;
      tc++;
      @(negedge clk);
    end
    chk(tc == exp_n, "R5 track length", tc, exp_n);
    while (hold && hc < 200) begin
      if (!busy) nb++;
      cmp_in = (hc < 12) ? pat[11 - hc] : 1'b0;
      hc++;
      @(negedge clk);
    end
    cmp_in = 1'b0;
    chk(hc == 13, "R6 hold length", hc, 13);
    chk(nb == 0, "R10 busy during sequence", nb, 0);
    chk(done == 1'b1, "R6 done strobe", done, 1);
    chk(result == pat, "R7 result MSB first", result, pat);
    if (cont) chk(track == 1'b1, "R9 free-run restart", track, 1);
    else      chk(busy == 1'b0, "R10 busy cleared at done", busy, 0);
  endtask

  task automatic pulse_sw();
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    chk({track, hold, busy, done} == 4'b0, "R1 flags in reset", {track, hold, busy, done}, 0);
    chk(result == 12'h0, "R1 result in reset", result, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk({track, hold, busy, done} == 4'b0, "R1 flags after release", {track, hold, busy, done}, 0);
  endtask

  task automatic t_soft(input bit sd, input bit un, input int n, input logic [11:0] pat);
    src_sel = 3'b111; auto_shdn = sd; gain_unity = un;
    @(negedge clk);
    pulse_sw();
    chk(track && busy, "R2 software start", {track, busy}, 3);
    do_conv(n, pat, 1'b0);
    @(negedge clk);
    chk(done == 1'b0, "R6 done one cycle", done, 0);
  endtask

  task automatic t_timers();
    auto_shdn = 1'b0; gain_unity = 1'b1;
    for (int i = 0; i < 3; i++) begin
      src_sel = 3'(i);
      @(negedge clk);
      tmr_stb[i] = 1'b1;
      @(negedge clk);
      tmr_stb[i] = 1'b0;
      chk(track == 1'b1, "R2 timer start", track, 1);
      do_conv(3, 12'h111 << i, 1'b0);
      @(negedge clk);
    end
  endtask

  task automatic t_pin();
    auto_shdn = 1'b1; gain_unity = 1'b1;
    src_sel = 3'b100;
    @(negedge clk);
    conv_pin = 1'b1;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R3 rise not early", busy, 0);
    @(negedge clk);
    chk(track == 1'b1, "R3 rise start", track, 1);
    do_conv(13, 12'h800, 1'b0);
    @(negedge clk);
    src_sel = 3'b101;
    @(negedge clk);
    conv_pin = 1'b0;
    @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R3 fall not early", busy, 0);
    @(negedge clk);
    chk(track == 1'b1, "R3 fall start", track, 1);
    do_conv(13, 12'h001, 1'b0);
    @(negedge clk);
  endtask

  task automatic t_ignore();
    auto_shdn = 1'b0; gain_unity = 1'b1;
    src_sel = 3'b000;
    @(negedge clk);
    tmr_stb = 3'b110; sw_start = 1'b1;
    @(negedge clk);
    tmr_stb = 3'b000; sw_start = 1'b0;
    @(negedge clk);
    chk(busy == 1'b0, "R4 unselected sources", busy, 0);
    src_sel = 3'b011;
    @(negedge clk);
    tmr_stb = 3'b111; sw_start = 1'b1; conv_pin = 1'b1;
    @(negedge clk);
    tmr_stb = 3'b000; sw_start = 1'b0;
    repeat (4) @(negedge clk);
    chk(busy == 1'b0, "R4 unused code", busy, 0);
    conv_pin = 1'b0;
    repeat (4) @(negedge clk);
    src_sel = 3'b111;
    @(negedge clk);
    pulse_sw();
    sw_start = 1'b1;
    @(negedge clk);
    sw_start = 1'b0;
    do_conv(2, 12'h5A5, 1'b0);
    @(negedge clk);
    chk(busy == 1'b0, "R8 retrigger ignored", busy, 0);
  endtask

  task automatic t_free(input bit un, input int n);
    auto_shdn = 1'b1; gain_unity = un;
    src_sel = 3'b110;
    @(negedge clk);
    chk(track == 1'b1, "R9 free-run start", track, 1);
    do_conv(n, 12'hA5C, 1'b1);
    do_conv(n, 12'h3F0, 1'b1);
    src_sel = 3'b111;
    do_conv(n, 12'hFFF, 1'b0);
    @(negedge clk);
    chk(busy == 1'b0, "R9 free-run stops", busy, 0);
  endtask

  task automatic t_reset_mid();
    src_sel = 3'b111; auto_shdn = 1'b0; gain_unity = 1'b0;
    @(negedge clk);
    pulse_sw();
    repeat (46) @(negedge clk);
    chk(hold == 1'b1, "R6 in hold before reset", hold, 1);
    rst_n = 1'b0;
    #1;
    chk({track, hold, busy, done} == 4'b0, "R1 flags mid reset", {track, hold, busy, done}, 0);
    chk(result == 12'h0, "R1 result mid reset", result, 0);
    @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0; src_sel = 3'b111; tmr_stb = '0; conv_pin = 1'b0;
    sw_start = 1'b0; auto_shdn = 1'b0; gain_unity = 1'b1; cmp_in = 1'b0;
    @(negedge clk);
    t_reset();
    t_soft(1'b1, 1'b1, 13, 12'hA5C);
    t_soft(1'b1, 1'b0, 93, 12'h3F0);
    t_soft(1'b0, 1'b1, 3,  12'hFFF);
    t_soft(1'b0, 1'b0, 43, 12'h000);
    t_timers();
    t_pin();
    t_ignore();
    t_free(1'b1, 3);
    t_free(1'b0, 43);
    t_reset_mid();
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule